// File: doc/BRIEF.md
# Parallel Configuration Loader and Readback Engine

This block configures a programmable target device through an 8-bit parallel slave port. It can also read configuration data back out of the target. A host starts a load or a readback with a one-cycle command and a byte count. During a load the block pulls bytes from the host one at a time and pulses `wr_take` for each one. During a readback it hands each byte to the host with a one-cycle `rd_valid` strobe. Each session ends with a one-cycle `sess_done` pulse or, on a timeout, a one-cycle `sess_err` pulse.

On the target side the block sequences the programming strobe, chip select, write enable and configuration clock. It drives the data bus only while a load is in progress. It samples the target's init, busy and done indications. The configuration clock rests high. Every byte costs one low phase and one high phase, and the target captures data on the rising edge. An optional busy flow control repeats the clock pulse without moving to the next byte while the target is not ready.

Top module: `cfg_par_loader`

## Requirements
- R1: After reset and while idle, `tgt_prog`, `tgt_cs`, `tgt_write`, `tgt_d_oe`, `sess_done` and `sess_err` are 0 and `tgt_cclk` is 1.
- R2: A load command holds `tgt_prog` at 1 for exactly PROG_CYC cycles and then releases it. The block then waits for `tgt_init`=1 together with `tgt_busy`=0. If that does not happen within TIMEOUT_CYC cycles, the load aborts with `sess_err`.
- R3: Each load byte is driven on `tgt_d_out` with `tgt_d_oe`=1, `tgt_cs`=1 and `tgt_write`=1. It is followed by one `tgt_cclk` low phase and then a rise. The bytes arrive at the target in host order, one rising edge per byte.
- R4: With `cfg_busy_fc`=1, if `tgt_busy` is 1 when `tgt_cclk` has risen on a byte, the clock is pulsed again with the same byte on the bus until busy clears. If busy does not clear within TIMEOUT_CYC cycles, the load aborts.
- R5: After the last load byte, `tgt_cs` falls at least one cycle before `tgt_write` falls.
- R6: After release, `tgt_cclk` keeps pulsing until `tgt_done`=1, and then `sess_done` pulses. If done does not rise within TIMEOUT_CYC cycles, `sess_err` pulses instead.
- R7: A readback asserts `tgt_cs` with `tgt_write`=0 and `tgt_d_oe`=0. Each byte is one low then high `tgt_cclk` phase, and `tgt_d_in` is sampled while the clock is high. The byte is presented on `rd_data` with `rd_valid` the next cycle, in order.
- R8: When a readback ends, `tgt_cs` is released and exactly one further low-to-high `tgt_cclk` pulse follows before `sess_done`.
- R9: An abort pulses `sess_err` for one cycle, never together with `sess_done`, and leaves all target control lines at their idle levels as in R1.
- R10: With `cfg_busy_fc`=0, `tgt_busy` has no effect during data transfer: a load of N bytes yields exactly N rising edges with chip select and write asserted.
- R11: `tgt_d_oe` is 1 only while `tgt_write` is 1, and it stays 0 throughout readback and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_busy_fc | input | 1 | 1 enables busy flow control during data transfer |
| cmd_load | input | 1 | One-cycle pulse to start a load (idle only) |
| cmd_read | input | 1 | One-cycle pulse to start a readback (idle only, load wins) |
| xfer_len | input | CNT_W | Number of bytes in the session, latched at the command |
| wr_data | input | DATA_W | Next load byte from the host stream |
| wr_take | output | 1 | Block consumes `wr_data` this cycle |
| rd_data | output | DATA_W | Readback byte |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| sess_done | output | 1 | One-cycle pulse: session completed |
| sess_err | output | 1 | One-cycle pulse: session aborted on timeout |
| tgt_prog | output | 1 | Programming strobe to target, 1 = asserted |
| tgt_cs | output | 1 | Chip select, 1 = asserted |
| tgt_write | output | 1 | Write enable, 1 = asserted |
| tgt_cclk | output | 1 | Configuration clock, idles high |
| tgt_d_out | output | DATA_W | Data bus output value |
| tgt_d_oe | output | 1 | Data bus output enable |
| tgt_d_in | input | DATA_W | Data bus input value |
| tgt_init | input | 1 | Target init indication, 1 = released |
| tgt_busy | input | 1 | Target busy, 1 = not ready |
| tgt_done | input | 1 | Target done, 1 = configured |

## Verification
The bench builds the block with TIMEOUT_CYC=60, PROG_CYC=3, CNT_W=8 and the busy flow-control variant generated in. With the short timeout, a stuck init, a stuck busy and a done that never rises each end in an abort within tens of cycles rather than a million. With the flow-control hardware present, the same build can exercise both repeated clock pulses and ignored busy through the `cfg_busy_fc` input. A behavioural target model records every rising clock edge, and the bench compares the captured sequence, including repeated bytes, against an expected list computed from the busy window it injected.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

   // one state per clock phase of the target interface
   typedef enum logic [4:0] {
      ST_IDLE,
      ST_PROG,
      ST_WAIT,
      ST_SETUP,
      ST_PUT,
      ST_LO,
      ST_HI,
      ST_BLO,
      ST_RELCS,
      ST_RELWR,
      ST_DLO,
      ST_DHI,
      ST_RBSET,
      ST_RBLO,
      ST_RBHI,
      ST_RBEND,
      ST_RBTAIL,
      ST_FIN,
      ST_ABORT
   } cfgl_state_e;

endpackage

// File: rtl/cfgl_timer.sv
module cfgl_timer #(
   parameter int LIMIT = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic expired
);
   localparam int W = $clog2(LIMIT + 1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (cnt != W'(LIMIT))
         cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == W'(LIMIT));
endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq
   import cfgl_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int PROG_CYC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_load,
   input  logic             cmd_read,
   input  logic [CNT_W-1:0] xfer_len,
   input  logic             tgt_init,
   input  logic             tgt_busy,
   input  logic             busy_flow,
   input  logic             tgt_done,
   input  logic             tmo,
   output cfgl_state_e      st,
   output logic             tmr_clr
);
   localparam int PW = $clog2(PROG_CYC + 1);

   cfgl_state_e      nxt;
   logic [CNT_W-1:0] rem;
   logic [PW-1:0]    pcnt;

   always_comb begin
      nxt     = st;
      tmr_clr = 1'b0;
      case (st)
         ST_IDLE:
            if (cmd_load)      nxt = ST_PROG;
            else if (cmd_read) nxt = ST_RBSET;
         ST_PROG: begin
            tmr_clr = 1'b1;
            if (pcnt == PW'(PROG_CYC - 1)) nxt = ST_WAIT;
         end
         ST_WAIT:
            if (tgt_init && !tgt_busy) nxt = ST_SETUP;
            else if (tmo)              nxt = ST_ABORT;
         ST_SETUP:
            nxt = (rem == '0) ? ST_RELCS : ST_PUT;
         ST_PUT: begin
            tmr_clr = 1'b1;
            nxt     = ST_LO;
         end
         ST_LO:
            nxt = ST_HI;
         ST_HI:
            if (busy_flow)        nxt = tmo ? ST_ABORT : ST_BLO;
            else if (rem == '0)   nxt = ST_RELCS;
            else                  nxt = ST_PUT;
         ST_BLO:
            nxt = ST_HI;
         ST_RELCS:
            nxt = ST_RELWR;
         ST_RELWR: begin
            tmr_clr = 1'b1;
            nxt     = ST_DLO;
         end
         ST_DLO:
            nxt = ST_DHI;
         ST_DHI:
            if (tgt_done) nxt = ST_FIN;
            else if (tmo) nxt = ST_ABORT;
            else          nxt = ST_DLO;
         ST_RBSET:
            nxt = (rem == '0) ? ST_RBEND : ST_RBLO;
         ST_RBLO:
            nxt = ST_RBHI;
         ST_RBHI:
            nxt = (rem == '0) ? ST_RBEND : ST_RBLO;
         ST_RBEND:
            nxt = ST_RBTAIL;
         ST_RBTAIL:
            nxt = ST_FIN;
         ST_FIN, ST_ABORT:
            nxt = ST_IDLE;
         default:
            nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         rem  <= '0;
         pcnt <= '0;
      end else begin
         st   <= nxt;
         pcnt <= (st == ST_PROG) ? pcnt + 1'b1 : '0;
         if (st == ST_IDLE && (cmd_load || cmd_read))
            rem <= xfer_len;
         else if (st == ST_PUT || st == ST_RBLO)
            rem <= rem - 1'b1;
      end
   end
endmodule

// File: rtl/cfgl_pins.sv
module cfgl_pins
   import cfgl_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cfgl_state_e       st,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] tgt_d_in,
   output logic              tgt_prog,
   output logic              tgt_cs,
   output logic              tgt_write,
   output logic              tgt_cclk,
   output logic              tgt_d_oe,
   output logic [DATA_W-1:0] tgt_d_out,
   output logic              wr_take,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              sess_done,
   output logic              sess_err
);
   always_comb begin
      tgt_prog  = (st == ST_PROG);
      tgt_cs    = st inside {ST_SETUP, ST_PUT, ST_LO, ST_HI, ST_BLO,
                             ST_RBSET, ST_RBLO, ST_RBHI};
      tgt_write = st inside {ST_SETUP, ST_PUT, ST_LO, ST_HI, ST_BLO, ST_RELCS};
      tgt_d_oe  = st inside {ST_SETUP, ST_PUT, ST_LO, ST_HI, ST_BLO, ST_RELCS};
      tgt_cclk  = !(st inside {ST_LO, ST_BLO, ST_DLO, ST_RBLO, ST_RBEND});
      wr_take   = (st == ST_PUT);
      sess_done = (st == ST_FIN);
      sess_err  = (st == ST_ABORT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_d_out <= '0;
         rd_data   <= '0;
         rd_valid  <= 1'b0;
      end else begin
         if (st == ST_PUT)
            tgt_d_out <= wr_data;
         rd_valid <= (st == ST_RBHI);
         if (st == ST_RBHI)
            rd_data <= tgt_d_in;
      end
   end
endmodule

// File: rtl/cfg_par_loader.sv
module cfg_par_loader
   import cfgl_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 16,
   parameter int PROG_CYC    = 8,
   parameter int TIMEOUT_CYC = 1000000,
   parameter bit BUSY_FC_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_busy_fc,
   input  logic              cmd_load,
   input  logic              cmd_read,
   input  logic [CNT_W-1:0]  xfer_len,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_take,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              sess_done,
   output logic              sess_err,
   output logic              tgt_prog,
   output logic              tgt_cs,
   output logic              tgt_write,
   output logic              tgt_cclk,
   output logic [DATA_W-1:0] tgt_d_out,
   output logic              tgt_d_oe,
   input  logic [DATA_W-1:0] tgt_d_in,
   input  logic              tgt_init,
   input  logic              tgt_busy,
   input  logic              tgt_done
);
   // elaboration-time parameter checks
   if (DATA_W < 1)       begin : g_bad_dw  $error("DATA_W must be at least 1");       end
   if (CNT_W < 1)        begin : g_bad_cw  $error("CNT_W must be at least 1");        end
   if (PROG_CYC < 1)     begin : g_bad_pc  $error("PROG_CYC must be at least 1");     end
   if (TIMEOUT_CYC < 2)  begin : g_bad_to  $error("TIMEOUT_CYC must be at least 2");  end

   cfgl_state_e st;
   logic        tmr_clr;
   logic        tmo;
   logic        busy_flow;

   // busy flow-control hardware is a build option; the input picks it at run time
   if (BUSY_FC_EN) begin : g_fc
      assign busy_flow = tgt_busy & cfg_busy_fc;
   end else begin : g_no_fc
      assign busy_flow = 1'b0;
   end

   cfgl_timer #(.LIMIT(TIMEOUT_CYC)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_clr),
      .expired (tmo)
   );

   cfgl_seq #(.CNT_W(CNT_W), .PROG_CYC(PROG_CYC)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_load  (cmd_load),
      .cmd_read  (cmd_read),
      .xfer_len  (xfer_len),
      .tgt_init  (tgt_init),
      .tgt_busy  (tgt_busy),
      .busy_flow (busy_flow),
      .tgt_done  (tgt_done),
      .tmo       (tmo),
      .st        (st),
      .tmr_clr   (tmr_clr)
   );

   cfgl_pins #(.DATA_W(DATA_W)) i_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .st        (st),
      .wr_data   (wr_data),
      .tgt_d_in  (tgt_d_in),
      .tgt_prog  (tgt_prog),
      .tgt_cs    (tgt_cs),
      .tgt_write (tgt_write),
      .tgt_cclk  (tgt_cclk),
      .tgt_d_oe  (tgt_d_oe),
      .tgt_d_out (tgt_d_out),
      .wr_take   (wr_take),
      .rd_data   (rd_data),
      .rd_valid  (rd_valid),
      .sess_done (sess_done),
      .sess_err  (sess_err)
   );
endmodule

// File: rtl/cfgl_checker.sv
module cfgl_checker #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tgt_prog,
   input logic          tgt_cs,
   input logic          tgt_write,
   input logic          tgt_cclk,
   input logic          tgt_d_oe,
   input logic [DW-1:0] tgt_d_out,
   input logic          wr_take,
   input logic          rd_valid,
   input logic          sess_done,
   input logic          sess_err
);
   // R2: programming strobe never overlaps a data phase
   a_r2_prog_alone: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_prog |-> (!tgt_cs && !tgt_write && !tgt_d_oe));

   // R4: the bus byte only moves after a take, so busy repeats keep it
   a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_d_oe && $past(tgt_d_oe) && !$past(wr_take)) |-> $stable(tgt_d_out));

   // R5: write falls only once chip select is already gone (abort excepted)
   a_r5_cs_first: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(tgt_write) && !sess_err) |-> !$past(tgt_cs));

   // R7: readback bytes come from a high clock phase with write inactive
   a_r7_rd_window: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(tgt_cclk) && $past(tgt_cs) && !$past(tgt_write)));

   // R9: completion and abort are exclusive
   a_r9_one_status: assert property (@(posedge clk) disable iff (!rst_n)
      !(sess_done && sess_err));

   // R9: after an abort all lines rest at idle
   a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sess_err |=> (!tgt_prog && !tgt_cs && !tgt_write && tgt_cclk && !tgt_d_oe));

   // R11: the bus driver is only on with write asserted
   a_r11_oe_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_d_oe |-> tgt_write);
endmodule

bind cfg_par_loader cfgl_checker #(.DW(DATA_W)) i_cfgl_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .tgt_prog  (tgt_prog),
   .tgt_cs    (tgt_cs),
   .tgt_write (tgt_write),
   .tgt_cclk  (tgt_cclk),
   .tgt_d_oe  (tgt_d_oe),
   .tgt_d_out (tgt_d_out),
   .wr_take   (wr_take),
   .rd_valid  (rd_valid),
   .sess_done (sess_done),
   .sess_err  (sess_err)
);

// File: tb/test_cfg_par_loader.sv
module test_cfg_par_loader;
   localparam int CLK_PERIOD = 10;
   localparam int DW   = 8;
   localparam int CW   = 8;
   localparam int PCYC = 3;
   localparam int TMO  = 60;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_busy_fc = 1'b0;
   logic          cmd_load = 1'b0;
   logic          cmd_read = 1'b0;
   logic [CW-1:0] xfer_len = '0;
   logic [DW-1:0] wr_data;
   logic          wr_take;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic          sess_done, sess_err;
   logic          tgt_prog, tgt_cs, tgt_write, tgt_cclk, tgt_d_oe;
   logic [DW-1:0] tgt_d_out;
   logic [DW-1:0] tgt_d_in = '0;
   logic          tgt_init = 1'b1;
   logic          tgt_busy = 1'b0;
   logic          tgt_done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_par_loader #(.DATA_W(DW), .CNT_W(CW), .PROG_CYC(PCYC),
                    .TIMEOUT_CYC(TMO), .BUSY_FC_EN(1'b1)) i_cfg_par_loader (
      .clk(clk), .rst_n(rst_n), .cfg_busy_fc(cfg_busy_fc),
      .cmd_load(cmd_load), .cmd_read(cmd_read), .xfer_len(xfer_len),
      .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data),
      .rd_valid(rd_valid), .sess_done(sess_done), .sess_err(sess_err),
      .tgt_prog(tgt_prog), .tgt_cs(tgt_cs), .tgt_write(tgt_write),
      .tgt_cclk(tgt_cclk), .tgt_d_out(tgt_d_out), .tgt_d_oe(tgt_d_oe),
      .tgt_d_in(tgt_d_in), .tgt_init(tgt_init), .tgt_busy(tgt_busy),
      .tgt_done(tgt_done));

   int total = 0, bad = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // ---------------- host stream and target model ----------------
   logic [DW-1:0] src [256];
   logic [DW-1:0] cap [512];
   logic [DW-1:0] rdbuf [256];
   int  ptr, take_seen, ncap, nrd;
   int  bk, bl, bleft, busy_stuck, done_after, dedges;
   int  init_delay, init_stuck, in_load, in_rb, rb_idx, tail, rb_bad, prog_hi;
   logic [DW-1:0] rb_key;
   time t_cs, t_wr;

   assign wr_data = src[ptr & 255];

   function automatic logic [DW-1:0] rbpat(input int i);
      return DW'(i * 37 + 5) ^ rb_key;
   endfunction

   // index into src expected at captured edge i
   function automatic int exp_idx(input int i, input int k, input int l);
      if (k == 0 || i < k) return i;
      if (i < k + l)       return k - 1;
      return i - l;
   endfunction

   always @(negedge clk) begin
      if (take_seen != 0) ptr++;
      take_seen = int'(wr_take);
      if (rd_valid) begin rdbuf[nrd & 255] = rd_data; nrd++; end
      if (tgt_prog) prog_hi++;
      if (in_rb != 0 && (tgt_write || tgt_d_oe || tgt_prog)) rb_bad++;
   end

   always @(posedge tgt_prog) begin tgt_init = 1'b0; tgt_done = 1'b0; dedges = 0; end
   always @(negedge tgt_prog) begin
      if (init_stuck == 0) begin
         repeat (init_delay) @(negedge clk);
         tgt_init = 1'b1;
      end
   end

   always @(posedge tgt_cclk) begin
      if (tgt_cs && tgt_write && tgt_d_oe) begin
         cap[ncap & 511] = tgt_d_out;
         ncap++;
         if (ncap == bk)     bleft = bl;
         else if (bleft > 0) bleft--;
         tgt_busy = (busy_stuck != 0) || (bleft > 0);
      end else if (!tgt_cs && !tgt_write) begin
         if (in_load != 0) begin
            dedges++;
            if (dedges >= done_after) tgt_done = 1'b1;
         end
         if (in_rb != 0) tail++;
      end
   end

   always @(negedge tgt_cclk)
      if (tgt_cs && !tgt_write) begin tgt_d_in = rbpat(rb_idx); rb_idx++; end
   always @(negedge tgt_cs)    t_cs = $time;
   always @(negedge tgt_write) t_wr = $time;

   // ---------------- session tasks ----------------
   task automatic wait_end(output int res, output int cyc);
      res = 0; cyc = 0;
      while (res == 0 && cyc < 5000) begin
         @(negedge clk);
         cyc++;
         if (sess_done) res = 1;
         else if (sess_err) res = 2;
      end
   endtask

   task automatic run_load(input int n, input int fc, input int k, input int l,
                           input int dafter, input int idly, input int istuck,
                           input int bstuck, output int res, output int cyc);
      ptr = 0; take_seen = 0; ncap = 0; bleft = 0; prog_hi = 0;
      bk = k; bl = l; done_after = dafter; init_delay = idly;
      init_stuck = istuck; busy_stuck = bstuck; tgt_busy = 1'b0;
      for (int i = 0; i < 256; i++) src[i] = DW'($urandom);
      in_load = 1;
      @(negedge clk);
      cfg_busy_fc = fc[0]; xfer_len = CW'(n); cmd_load = 1'b1;
      @(negedge clk);
      cmd_load = 1'b0;
      wait_end(res, cyc);
      in_load = 0; busy_stuck = 0; tgt_busy = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic check_idle(input string req);
      chk(!tgt_prog && !tgt_cs && !tgt_write && tgt_cclk && !tgt_d_oe
          && !sess_done && !sess_err, req,
          {tgt_prog, tgt_cs, tgt_write, tgt_cclk, tgt_d_oe}, 5'b00010);
   endtask

   task automatic check_caps(input int n, input int k, input int l, input string req);
      int errs = 0;
      for (int i = 0; i < n + l; i++)
         if (cap[i] != src[exp_idx(i, k, l)]) errs++;
      chk(errs == 0, req, errs, 0);
   endtask

   task automatic run_rb(input int n);
      int res, cyc, errs;
      nrd = 0; rb_idx = 0; tail = 0; rb_bad = 0; rb_key = DW'($urandom);
      in_rb = 1;
      @(negedge clk);
      xfer_len = CW'(n); cmd_read = 1'b1;
      @(negedge clk);
      cmd_read = 1'b0;
      wait_end(res, cyc);
      in_rb = 0;
      chk(res == 1, "R8 readback completes", res, 1);
      chk(nrd == n, "R7 readback byte count", nrd, n);
      errs = 0;
      for (int i = 0; i < n; i++) if (rdbuf[i] != rbpat(i)) errs++;
      chk(errs == 0, "R7 readback data order", errs, 0);
      chk(rb_bad == 0, "R11 no write/oe during readback (R7)", rb_bad, 0);
      chk(tail == 1, "R8 one trailing clock pulse", tail, 1);
      repeat (2) @(negedge clk);
   endtask

   // ---------------- main sequence ----------------
   initial begin
      int res, cyc, n, k, l, fc;
      void'($urandom(32'h5eed_c0f1));
      in_load = 0; in_rb = 0; ptr = 0; take_seen = 0; nrd = 0; ncap = 0;
      busy_stuck = 0; bleft = 0; bk = 0; bl = 0; rb_key = '0; rb_idx = 0;
      done_after = 1; init_delay = 2; init_stuck = 0; tail = 0; rb_bad = 0;
      repeat (3) @(negedge clk);
      check_idle("R1 reset state");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_idle("R1 idle after reset");

      // plain load, flow control off
      run_load(8, 0, 0, 0, 3, 2, 0, 0, res, cyc);
      chk(res == 1, "R6 load completes with done", res, 1);
      chk(prog_hi == PCYC, "R2 prog pulse width", prog_hi, PCYC);
      chk(ncap == 8, "R3 one edge per byte", ncap, 8);
      check_caps(8, 0, 0, "R3 byte order");
      chk(t_wr > t_cs, "R5 cs released before write", int'(t_wr - t_cs), 1);
      chk(dedges == 3, "R6 clock pulses until done", dedges, 3);
      check_idle("R1 idle after load");

      // busy repeats with flow control on
      run_load(6, 1, 3, 2, 2, 1, 0, 0, res, cyc);
      chk(res == 1, "R4 busy load completes", res, 1);
      chk(ncap == 8, "R4 extra pulses while busy", ncap, 8);
      check_caps(6, 3, 2, "R4 byte held during busy");

      // busy ignored with flow control off
      run_load(5, 0, 2, 3, 1, 1, 0, 0, res, cyc);
      chk(res == 1, "R10 load completes", res, 1);
      chk(ncap == 5, "R10 busy ignored", ncap, 5);
      check_caps(5, 0, 0, "R10 byte order");

      // init never released
      run_load(4, 0, 0, 0, 1, 1, 1, 0, res, cyc);
      chk(res == 2, "R2 init timeout aborts", res, 2);
      chk(cyc >= TMO, "R2 timeout not early", cyc, TMO);
      chk(ncap == 0, "R2 no data before init", ncap, 0);
      check_idle("R9 lines idle after abort");
      tgt_init = 1'b1;

      // busy stuck during data
      run_load(4, 1, 0, 0, 1, 1, 0, 1, res, cyc);
      chk(res == 2, "R4 busy timeout aborts", res, 2);
      check_idle("R9 lines idle after busy abort");

      // done never rises
      run_load(3, 0, 0, 0, 100000, 1, 0, 0, res, cyc);
      chk(res == 2, "R6 done timeout aborts", res, 2);
      check_idle("R9 lines idle after done abort");

      // random loads
      for (int t = 0; t < 5; t++) begin
         n  = 1 + int'($urandom % 20);
         fc = int'($urandom % 2);
         k  = 1 + int'($urandom % n);
         l  = int'($urandom % 4);
         run_load(n, fc, k, l, 1 + int'($urandom % 4), 1 + int'($urandom % 5), 0, 0, res, cyc);
         chk(res == 1, "R3 random load completes", res, 1);
         chk(ncap == n + (fc != 0 ? l : 0), "R4 R10 random edge count",
             ncap, n + (fc != 0 ? l : 0));
         check_caps(n, fc != 0 ? k : 0, fc != 0 ? l : 0, "R3 random byte sequence");
      end

      // readback
      run_rb(10);
      run_rb(1 + int'($urandom % 30));
      check_idle("R11 idle after readback");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule